// File: doc/BRIEF.md
# Register Stack with Full and Empty Flags

This block is a last-in, first-out store held in flip-flops. A 6-bit stack pointer addresses the item on top, and the item at that location is always visible on the data output. A push request writes a new word above the current top. A pull request removes the top word, so the word beneath it appears on the output. Two flag outputs report whether the stack is full or empty. A request that the stack cannot honour is dropped and signalled with a one-cycle error pulse.

The pointer advances before a push writes, so the first word lands at location 1. After the 64th push the pointer wraps to location 0 and the stack is full. A full stack and an empty stack both leave the pointer at 0. The two flags are therefore kept in their own flip-flops rather than derived from the pointer. The block serves as a fast return-address or operand stack beside a datapath, and is driven one request per clock.

Top module: `lifo_regstack`

## Requirements
- R1: After reset the pointer is 0, the empty flag is 1, the full flag is 0 and the error output is 0.
- R2: A push accepted while the full flag is 0 increments the pointer by one and stores the input word at the new pointer location. The word then appears on the top output in the next cycle, and the empty flag is cleared.
- R3: A pull accepted while the empty flag is 0 decrements the pointer by one. The word stored at the new pointer then appears on the top output in the next cycle.
- R4: The push that moves the pointer from 63 to 0 (the 64th word) sets the full flag. Before that push the full flag stays 0. The full and empty flags are never 1 together.
- R5: The pull that moves the pointer from 1 to 0 sets the empty flag. Any accepted pull clears the full flag.
- R6: A push while the full flag is 1 is rejected. The pointer, both flags and the top output keep their values, and the error output is 1 for exactly the following cycle.
- R7: A pull while the empty flag is 1 is rejected. The pointer and both flags keep their values, and the error output is 1 for exactly the following cycle.
- R8: A cycle with push and pull requested together is rejected whatever the flags are. It changes neither the pointer, the flags nor the top output, and it raises the error output for the following cycle.
- R9: Words come back in the reverse of the order in which they were pushed, across the full depth of the stack.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| push_req | input | 1 | Request to push wr_data |
| pull_req | input | 1 | Request to remove the top word |
| wr_data | input | 8 | Word to push |
| top_data | output | 8 | Word at the pointer location |
| sp | output | 6 | Stack pointer |
| full | output | 1 | Stack holds 64 words |
| empty | output | 1 | Stack holds no words |
| err | output | 1 | Previous cycle's request was rejected |

## Verification
The hardest states to reach are the two pointer wraps. A full stack and an empty stack share pointer value 0, and they differ only in the flag flip-flops. The stimulus drives 64 consecutive pushes from empty to reach full. It then issues a rejected push and a simultaneous push-and-pull there. From the full state it drains all 64 words, checking the reverse order, down to the empty state and a rejected pull.

// File: rtl/lifo_regstack.sv
module lifo_regstack #(
  parameter int AW = 6,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_req,
  input  logic          pull_req,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] top_data,
  output logic [AW-1:0] sp,
  output logic          full,
  output logic          empty,
  output logic          err
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] sp_inc, sp_dec;
  logic          both, do_push, do_pull, reject;

  assign both    = push_req && pull_req;
  assign do_push = push_req && !pull_req && !full;
  assign do_pull = pull_req && !push_req && !empty;
  assign reject  = both || (push_req && full) || (pull_req && empty);
  assign sp_inc  = sp + 1'b1;
  assign sp_dec  = sp - 1'b1;
  assign top_data = mem[sp];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sp    <= '0;
      full  <= 1'b0;
      empty <= 1'b1;
      err   <= 1'b0;
    end else begin
      err <= reject;
      if (do_push) begin
        sp    <= sp_inc;
        empty <= 1'b0;
        if (sp_inc == '0) full <= 1'b1;
      end else if (do_pull) begin
        sp   <= sp_dec;
        full <= 1'b0;
        if (sp_dec == '0) empty <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[sp_inc] <= wr_data;
  end

  AST_PUSH_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    (push_req && !pull_req && !full) |=> (sp == $past(sp) + 1'b1) && !empty); // R2
  AST_PUSH_VISIBLE: assert property (@(posedge clk) disable iff (!rst_n)
    (push_req && !pull_req && !full) |=> top_data == $past(wr_data)); // R2
  AST_PULL_RETREAT: assert property (@(posedge clk) disable iff (!rst_n)
    (pull_req && !push_req && !empty) |=> (sp == $past(sp) - 1'b1) && !full); // R3
  AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(full && empty)); // R4
  AST_FULL_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> sp == '0); // R4
  AST_EMPTY_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    empty |-> sp == '0); // R5
  AST_FULL_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
    (push_req && full) |=> err && full && $stable(sp)); // R6
  AST_EMPTY_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
    (pull_req && empty) |=> err && empty && $stable(sp)); // R7
  AST_BOTH_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
    (push_req && pull_req) |=> err && $stable(sp) && $stable(full) && $stable(empty)); // R8
  AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    (!push_req && !pull_req) |=> !err); // R6
endmodule

// File: tb/lifo_regstack_tb.sv
`timescale 1ns/1ps
module lifo_regstack_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       push_req = 1'b0;
  logic       pull_req = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] top_data;
  logic [5:0] sp;
  logic       full, empty, err;
  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  lifo_regstack dut_i (
    .clk(clk), .rst_n(rst_n), .push_req(push_req), .pull_req(pull_req),
    .wr_data(wr_data), .top_data(top_data), .sp(sp), .full(full),
    .empty(empty), .err(err)
  );

  function automatic logic [7:0] val(int i);
    return 8'((i * 7 + 3) & 8'hFF);
  endfunction

  task automatic chk(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic step(logic pu, logic pl, logic [7:0] d);
    push_req = pu; pull_req = pl; wr_data = d;
    @(posedge clk); #1;
    push_req = 1'b0; pull_req = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1", "sp", sp, 0);
    chk("R1", "empty", empty, 1);
    chk("R1", "full", full, 0);
    chk("R1", "err", err, 0);
  endtask

  task automatic t_three_push_pull();
    logic [7:0] d [3] = '{8'hA1, 8'hB2, 8'hC3};
    for (int i = 0; i < 3; i++) begin
      step(1, 0, d[i]);
      chk("R2", "sp", sp, i + 1);
      chk("R2", "top", top_data, d[i]);
      chk("R2", "empty", empty, 0);
    end
    chk("R2", "sp after three", sp, 3);
    for (int i = 2; i >= 1; i--) begin
      step(0, 1, 8'h00);
      chk("R3", "sp", sp, i);
      chk("R9", "top", top_data, d[i-1]);
      chk("R5", "empty", empty, 0);
    end
    step(0, 1, 8'h00);
    chk("R5", "sp", sp, 0);
    chk("R5", "empty", empty, 1);
  endtask

  task automatic t_pull_empty();
    step(0, 1, 8'h00);
    chk("R7", "err", err, 1);
    chk("R7", "sp", sp, 0);
    chk("R7", "empty", empty, 1);
    chk("R7", "full", full, 0);
    @(posedge clk); #1;
    chk("R7", "err one cycle", err, 0);
  endtask

  task automatic t_fill();
    for (int i = 1; i <= 63; i++) step(1, 0, val(i));
    chk("R4", "sp at 63", sp, 63);
    chk("R4", "full before last", full, 0);
    step(1, 0, val(64));
    chk("R4", "full", full, 1);
    chk("R4", "empty", empty, 0);
    chk("R4", "sp wrapped", sp, 0);
    chk("R2", "top", top_data, val(64));
  endtask

  task automatic t_push_full();
    step(1, 0, 8'hEE);
    chk("R6", "err", err, 1);
    chk("R6", "sp", sp, 0);
    chk("R6", "full", full, 1);
    chk("R6", "top", top_data, val(64));
    @(posedge clk); #1;
    chk("R6", "err one cycle", err, 0);
  endtask

  task automatic t_both();
    step(1, 1, 8'h11);
    chk("R8", "err full", err, 1);
    chk("R8", "full", full, 1);
    chk("R8", "sp", sp, 0);
    step(0, 1, 8'h00);
    chk("R5", "full cleared", full, 0);
    chk("R3", "sp", sp, 63);
    chk("R9", "top", top_data, val(63));
    step(1, 1, 8'h22);
    chk("R8", "err mid", err, 1);
    chk("R8", "sp mid", sp, 63);
    chk("R8", "top mid", top_data, val(63));
    chk("R8", "flags mid", {full, empty}, 0);
  endtask

  task automatic t_drain();
    int bad = 0;
    for (int k = 62; k >= 1; k--) begin
      step(0, 1, 8'h00);
      if (top_data != val(k) || sp != 6'(k)) bad++;
    end
    chk("R9", "reverse order mismatches", bad, 0);
    step(0, 1, 8'h00);
    chk("R5", "empty after drain", empty, 1);
    chk("R5", "sp after drain", sp, 0);
  endtask

  initial begin
    #1_000_000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #12 rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_three_push_pull();
    t_pull_empty();
    t_fill();
    t_push_full();
    t_both();
    t_drain();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule